// File: doc/BRIEF.md
# Audio Level Noise Gate

The block watches a stream of two's-complement audio samples and closes a gate once the signal has stayed quiet for a fixed window of sample periods. It takes a 5-bit threshold code that selects the quiet level in 1.5 dB steps. It also takes a 2-bit action code that decides what a closed gate does. The gate can freeze the amplifier gain, zero the output samples, walk the gain down to a floor, or walk it down and then zero the samples.

Samples arrive with a one-cycle strobe. The block returns each sample one cycle later with a valid flag, possibly zeroed, together with a mute flag and a gain word for an external amplifier model. While the gate is open, the gain word follows the requested gain input. A single sample at or above the threshold reopens the gate, and the gain jumps back to the value it held when the gate closed.

Top module: `noise_gate`

## Requirements
- R1: While rst_ni is low, gain_o, mute_o, valid_o and data_o are all zero.
- R2: Threshold code c selects the magnitude floor(2^(DW-1) * 10^((-76.5 + 1.5*c)/20)). A sample is quiet when its absolute value is strictly below this magnitude. For DW=16, code 0 gives 4, code 16 gives 77 and code 31 gives 1036.
- R3: With en_i high, the gate closes on the QUIET_CNT-th consecutive quiet strobe. A strobe whose sample is not quiet restarts the count from zero.
- R4: Action code 0 (hold) keeps gain_o constant while the gate is closed and never asserts mute_o.
- R5: Action code 1 (mute) asserts mute_o while the gate is closed, starting with the output of the strobe that closed it. data_o reads zero while mute_o is high.
- R6: Action code 2 (fade) lowers gain_o by one every RAMP_DIV strobes after closing, stops at GAIN_MIN, and never asserts mute_o.
- R7: Action code 3 (fade then mute) ramps the gain as in R6 and asserts mute_o only once gain_o has reached GAIN_MIN.
- R8: With en_i low, the gate is open, mute_o is low, data_o carries each strobed sample, and gain_o follows gain_i. Clearing en_i opens a closed gate.
- R9: A strobe whose sample is not quiet opens a closed gate. In the output of that strobe, mute_o is low, data_o carries the sample and gain_o equals the gain held at the moment of closing.
- R10: valid_o is high for exactly the cycle after each strobe, and data_o then shows that strobe's sample unless it is muted.
- R11: While the gate is open, gain_o equals gain_i with one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strobe_i | input | 1 | One-cycle pulse marking a new sample |
| sample_i | input | DW | Two's-complement input sample |
| en_i | input | 1 | Gate enable |
| thr_code_i | input | 5 | Threshold code, 1.5 dB per step |
| type_i | input | 2 | Gate action: 0 hold, 1 mute, 2 fade, 3 fade then mute |
| gain_i | input | GW | Requested amplifier gain |
| gain_o | output | GW | Gain sent to the amplifier model |
| mute_o | output | 1 | Output samples are forced to zero |
| valid_o | output | 1 | data_o carries a new sample |
| data_o | output | DW | Gated output sample |

## Verification
The assertions assume that the action code stays constant across any cycle pair they compare. They also assume the requested gain is at or above GAIN_MIN when the gate closes. The bench changes the action code, threshold and enable only between sample bursts, with idle cycles around each change, and keeps gain_i at a fixed value above the floor. Strobes are always separated by at least one idle cycle, so each output is scored before the next sample arrives.

// File: rtl/ng_pkg.sv
package ng_pkg;
  localparam int NG_CODE_W = 5;
  localparam int NG_NCODE  = 1 << NG_CODE_W;

  typedef enum logic [1:0] {
    NG_HOLD      = 2'd0,
    NG_MUTE      = 2'd1,
    NG_FADE      = 2'd2,
    NG_FADE_MUTE = 2'd3
  } ng_mode_e;

  // linear magnitude for a threshold code, full scale = 2^(dw-1)
  function automatic int thr_lin(input int code, input int dw);
    real db;
    db = -76.5 + 1.5 * code;
    return $rtoi((2.0 ** (dw - 1)) * (10.0 ** (db / 20.0)));
  endfunction
endpackage

// File: rtl/ng_level_det.sv
module ng_level_det #(
  parameter int DW = 16
) (
  input  logic [DW-1:0]                sample_i,
  input  logic [ng_pkg::NG_CODE_W-1:0] code_i,
  output logic                         below_o
);
  logic [DW-1:0] thr_tab [ng_pkg::NG_NCODE];
  logic [DW-1:0] mag;

  for (genvar i = 0; i < ng_pkg::NG_NCODE; i++) begin : g_thr
    assign thr_tab[i] = DW'(ng_pkg::thr_lin(i, DW));
  end

  // unsigned DW bits hold |most negative| exactly
  assign mag     = sample_i[DW-1] ? (~sample_i + 1'b1) : sample_i;
  assign below_o = mag < thr_tab[code_i];
endmodule

// File: rtl/ng_quiet_timer.sv
module ng_quiet_timer #(
  parameter int QUIET_CNT = 12000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic strobe_i,
  input  logic below_i,
  output logic active_o,
  output logic enter_o,
  output logic release_o
);
  localparam int CW = $clog2(QUIET_CNT + 1);

  logic [CW-1:0] cnt_q;
  logic          act_q;
  logic          hit;

  assign hit       = cnt_q == CW'(QUIET_CNT - 1);
  assign enter_o   = en_i & strobe_i & below_i & ~act_q & hit;
  assign release_o = act_q & (~en_i | (strobe_i & ~below_i));
  assign active_o  = act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (strobe_i) begin
      if (!below_i) begin
        cnt_q <= '0;
        act_q <= 1'b0;
      end else if (!act_q) begin
        if (hit) begin
          cnt_q <= '0;
          act_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ng_gain_ctrl.sv
module ng_gain_ctrl #(
  parameter int GW       = 6,
  parameter int RAMP_DIV = 4,
  parameter int GAIN_MIN = 0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [GW-1:0] gain_i,
  input  logic          active_i,
  input  logic          enter_i,
  input  logic          release_i,
  input  logic          strobe_i,
  input  logic          ramp_i,
  output logic [GW-1:0] gain_o,
  output logic          at_min_o
);
  localparam int RW = (RAMP_DIV > 1) ? $clog2(RAMP_DIV) : 1;

  logic [GW-1:0] gain_q, save_q;
  logic [RW-1:0] rc_q;
  logic          step;

  assign step     = rc_q == RW'(RAMP_DIV - 1);
  assign gain_o   = gain_q;
  assign at_min_o = gain_q <= GW'(GAIN_MIN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gain_q <= '0;
      save_q <= '0;
      rc_q   <= '0;
    end else if (enter_i) begin
      save_q <= gain_q;
      rc_q   <= '0;
    end else if (release_i) begin
      gain_q <= save_q;
    end else if (active_i) begin
      if (strobe_i && ramp_i) begin
        if (step) begin
          rc_q <= '0;
          if (!at_min_o) gain_q <= gain_q - 1'b1;
        end else begin
          rc_q <= rc_q + 1'b1;
        end
      end
    end else begin
      gain_q <= gain_i;
    end
  end
endmodule

// File: rtl/noise_gate.sv
module noise_gate #(
  parameter int DW        = 16,
  parameter int GW        = 6,
  parameter int QUIET_CNT = 12000,
  parameter int RAMP_DIV  = 4,
  parameter int GAIN_MIN  = 0
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         strobe_i,
  input  logic [DW-1:0]                sample_i,
  input  logic                         en_i,
  input  logic [ng_pkg::NG_CODE_W-1:0] thr_code_i,
  input  logic [1:0]                   type_i,
  input  logic [GW-1:0]                gain_i,
  output logic [GW-1:0]                gain_o,
  output logic                         mute_o,
  output logic                         valid_o,
  output logic [DW-1:0]                data_o
);
  import ng_pkg::*;

  logic below, gate_act, gate_enter, gate_release, at_min, ramp;
  logic [DW-1:0] data_q;
  logic valid_q;
  ng_mode_e mode;

  assign mode = ng_mode_e'(type_i);
  assign ramp = (mode == NG_FADE) || (mode == NG_FADE_MUTE);

  ng_level_det #(.DW(DW)) u_lvl (
    .sample_i (sample_i),
    .code_i   (thr_code_i),
    .below_o  (below)
  );

  ng_quiet_timer #(.QUIET_CNT(QUIET_CNT)) u_tmr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .strobe_i  (strobe_i),
    .below_i   (below),
    .active_o  (gate_act),
    .enter_o   (gate_enter),
    .release_o (gate_release)
  );

  ng_gain_ctrl #(.GW(GW), .RAMP_DIV(RAMP_DIV), .GAIN_MIN(GAIN_MIN)) u_gain (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .gain_i    (gain_i),
    .active_i  (gate_act),
    .enter_i   (gate_enter),
    .release_i (gate_release),
    .strobe_i  (strobe_i),
    .ramp_i    (ramp),
    .gain_o    (gain_o),
    .at_min_o  (at_min)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= strobe_i;
      if (strobe_i) data_q <= sample_i;
    end
  end

  assign mute_o  = en_i & gate_act &
                   ((mode == NG_MUTE) | ((mode == NG_FADE_MUTE) & at_min));
  assign valid_o = valid_q;
  assign data_o  = mute_o ? '0 : data_q;
endmodule

// File: rtl/ng_checker.sv
module ng_checker #(
  parameter int DW       = 16,
  parameter int GW       = 6,
  parameter int GAIN_MIN = 0
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          en_i,
  input logic          strobe_i,
  input logic [1:0]    type_i,
  input logic [DW-1:0] sample_i,
  input logic [DW-1:0] data_o,
  input logic [GW-1:0] gain_o,
  input logic          mute_o,
  input logic          gate_act
);
  AST_ENTRY_ON_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gate_act) |-> $past(strobe_i && en_i)); // R3

  AST_HOLD_GAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_act && $past(gate_act) && type_i == 2'd0 && $past(type_i) == 2'd0)
      |-> $stable(gain_o)); // R4

  AST_RAMP_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_act && $past(gate_act))
      |-> (gain_o == $past(gain_o) || gain_o == $past(gain_o) - 1'b1)); // R6

  AST_MUTE_AT_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mute_o && type_i == 2'd3) |-> (gain_o <= GW'(GAIN_MIN))); // R7

  AST_EN_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !gate_act); // R8

  AST_PASS_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && !en_i) |=> (en_i || data_o == $past(sample_i))); // R8
endmodule

bind noise_gate ng_checker #(.DW(DW), .GW(GW), .GAIN_MIN(GAIN_MIN)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .en_i     (en_i),
  .strobe_i (strobe_i),
  .type_i   (type_i),
  .sample_i (sample_i),
  .data_o   (data_o),
  .gain_o   (gain_o),
  .mute_o   (mute_o),
  .gate_act (gate_act)
);

// File: tb/tb_noise_gate.sv
module tb_noise_gate;
  localparam int DW = 16, GW = 6, QC = 8, RD = 2, GMIN = 0, G = 5;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic strobe_i = 1'b0, en_i = 1'b0;
  logic [DW-1:0] sample_i = '0;
  logic [4:0] thr_code_i = '0;
  logic [1:0] type_i = '0;
  logic [GW-1:0] gain_i = GW'(G);
  logic [GW-1:0] gain_o;
  logic mute_o, valid_o;
  logic [DW-1:0] data_o;

  always #10 clk = ~clk;

  noise_gate #(.DW(DW), .GW(GW), .QUIET_CNT(QC), .RAMP_DIV(RD), .GAIN_MIN(GMIN)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .strobe_i(strobe_i), .sample_i(sample_i),
    .en_i(en_i), .thr_code_i(thr_code_i), .type_i(type_i), .gain_i(gain_i),
    .gain_o(gain_o), .mute_o(mute_o), .valid_o(valid_o), .data_o(data_o)
  );

  typedef struct {
    logic [DW-1:0] data;
    logic          mute;
    logic [GW-1:0] gain;
    string         tag;
  } exp_t;

  exp_t sb[$];
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  // reference model state
  int mcnt = 0, mgain = G, msave = G, mrc = 0;
  bit mact = 0, m_en = 0;
  int m_type = 0, m_code = 0;

  function automatic int thr(input int code);
    return $rtoi((2.0 ** (DW - 1)) * (10.0 ** ((-76.5 + 1.5 * code) / 20.0)));
  endfunction

  task automatic check(input string tag, input bit ok, input int act, input int exp_v);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp_v);
    end
  endtask

  task automatic send(input int s, input string tag);
    int a;
    bit below, mute;
    exp_t e;
    @(negedge clk);
    sample_i = DW'(s);
    strobe_i = 1'b1;
    a = (s < 0) ? -s : s;
    below = a < thr(m_code);
    if (!m_en) begin
      mact = 0; mcnt = 0; mgain = G;
    end else if (!below) begin
      mgain = mact ? msave : G; mact = 0; mcnt = 0;
    end else if (!mact) begin
      if (mcnt == QC - 1) begin
        mact = 1; mcnt = 0; msave = G; mrc = 0;
      end else mcnt++;
      mgain = G;
    end else if (m_type >= 2) begin
      if (mrc == RD - 1) begin
        mrc = 0;
        if (mgain > GMIN) mgain--;
      end else mrc++;
    end
    mute = m_en && mact && (m_type == 1 || (m_type == 3 && mgain <= GMIN));
    e.data = mute ? '0 : DW'(s);
    e.mute = mute;
    e.gain = GW'(mgain);
    e.tag  = tag;
    sb.push_back(e);
    @(negedge clk);
    strobe_i = 1'b0;
  endtask

  task automatic set_mode(input bit en, input int typ, input int code);
    @(negedge clk);
    if (m_en && !en && mact) mgain = msave;
    if (!en) begin mact = 0; mcnt = 0; end
    if (en && !m_en) mcnt = 0;
    en_i = en; type_i = 2'(typ); thr_code_i = 5'(code);
    m_en = en; m_type = typ; m_code = code;
    @(negedge clk);
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      if (valid_o) begin
        if (sb.size() == 0) begin
          check("R10 unexpected valid", 1'b0, 1, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check({e.tag, " data"}, data_o == e.data, int'($signed(data_o)), int'($signed(e.data)));
          check({e.tag, " mute"}, mute_o == e.mute, int'(mute_o), int'(e.mute));
          check({e.tag, " gain"}, gain_o == e.gain, int'(gain_o), int'(e.gain));
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      check("watchdog", 1'b0, 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset values
    check("R1 gain", gain_o == '0, int'(gain_o), 0);
    check("R1 mute", mute_o == 1'b0, int'(mute_o), 0);
    check("R1 valid", valid_o == 1'b0, int'(valid_o), 0);
    check("R1 data", data_o == '0, int'(data_o), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    check("R11 gain tracks", gain_o == GW'(G), int'(gain_o), G);

    // R2 table points
    check("R2 code0", thr(0) == 4, thr(0), 4);
    check("R2 code16", thr(16) == 77, thr(16), 77);
    check("R2 code31", thr(31) == 1036, thr(31), 1036);

    // R8 disabled: long quiet run passes through
    set_mode(0, 1, 31);
    for (int i = 0; i < 12; i++) send(3, "R8 disabled");
    send(-20000, "R8 disabled loud");

    // R5 mute, R3 window, R2 boundary with abs value
    set_mode(1, 1, 0);
    for (int i = 0; i < QC; i++) send(-3, "R5/R3 quiet run");
    check("R5 mute held", mute_o == 1'b1, int'(mute_o), 1);
    send(-4, "R9 release on equal magnitude");
    send(100, "R10 open pass");

    // R3 interrupted count
    for (int i = 0; i < 5; i++) send(2, "R3 partial");
    send(4, "R3 restart");
    for (int i = 0; i < QC; i++) send(1, "R3 full run");
    send(-32768, "R9 release full scale");

    // R6 fade, upper code boundary
    set_mode(1, 2, 31);
    for (int i = 0; i < QC + 2*G*RD + 4; i++) send(1035, "R6 fade");
    send(1036, "R9 release after fade");

    // R7 fade then mute
    set_mode(1, 3, 16);
    for (int i = 0; i < QC + 2*G*RD + 4; i++) send(-76, "R7 fade mute");
    send(77, "R9 release after fade mute");

    // R4 hold
    set_mode(1, 0, 16);
    for (int i = 0; i < QC + 6; i++) send(10, "R4 hold");
    check("R4 gate no mute", mute_o == 1'b0, int'(mute_o), 0);

    // R8 disable a closed mute gate
    set_mode(1, 1, 16);
    for (int i = 0; i < QC + 2; i++) send(10, "R5 close");
    check("R5 muted before disable", mute_o == 1'b1, int'(mute_o), 1);
    set_mode(0, 1, 16);
    check("R8 mute dropped", mute_o == 1'b0, int'(mute_o), 0);
    for (int i = 0; i < 3; i++) send(10, "R8 after disable");
    set_mode(1, 1, 16);
    for (int i = 0; i < QC - 1; i++) send(10, "R3 count restarted");

    repeat (4) @(negedge clk);
    check("R10 scoreboard drained", sb.size() == 0, sb.size(), 0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule